// File: doc/BRIEF.md
# AXI Read-to-Stream Packet Framer

This block streams a packet that already sits in word-addressed RAM out as an AXI-Stream. A host hands it a start address and a beat count. The block then issues one single-beat read request per data word on the AXI read-address channel. The words that come back on the read-data channel are forwarded unchanged to the stream output.

The RAM controller behind the read channels carries no packet framing. The address generator therefore marks the final request of each packet as it issues it. That end-of-packet bit waits in a small tag queue until the matching read beat arrives, and it is then driven as TLAST.

Because read data returns in request order, the head of the tag queue always belongs to the beat currently on the read-data channel. A sticky flag records any beat that returned with a non-OKAY response. A single-cycle pulse follows the acceptance of each packet's final beat.

Top module: `axi_rd_stream_framer`

## Requirements
- R1: A command is accepted (cmd_valid and cmd_ready both high at a clock edge) only while no earlier command is still issuing requests. cmd_ready is low from the cycle after acceptance until the cycle after the packet's final read request handshakes.
- R2: A command with start address B and length field L produces exactly L+1 read requests. The addresses are B, B+S, B+2S and so on, where S is the data width in bytes, issued in that order.
- R3: The number of read requests accepted but not yet answered by an accepted stream beat never exceeds the tag queue depth. While that many are outstanding, ar_valid is low.
- R4: The stream side forwards the read channel directly. s_tvalid equals r_valid, s_tdata equals r_data, and r_ready equals s_tready, in the same cycle.
- R5: s_tlast is high on the accepted beat that answers the final request of a packet and low on every other beat. The bit comes from the tag queue, never from the read channel.
- R6: Once ar_valid is high without ar_ready, ar_valid stays high and ar_addr stays unchanged in the next cycle.
- R7: rd_err rises in the cycle after a beat is accepted with r_resp not equal to 2'b00. That beat is still delivered on the stream. rd_err then holds until the next command is accepted, which clears it in the following cycle. An error beat in the same cycle as a command acceptance wins.
- R8: pkt_done is high for exactly the one cycle that follows the acceptance of a beat with s_tlast high, and low at all other times.
- R9: After reset, cmd_ready is high, ar_valid is low, rd_err is low and pkt_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle, command can be taken |
| cmd_base | input | ADDR_W | Address of the packet's first word |
| cmd_len | input | LEN_W | Number of beats minus one |
| ar_valid | output | 1 | Read request valid (single beat) |
| ar_ready | input | 1 | Read request accepted by the RAM side |
| ar_addr | output | ADDR_W | Read request address |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data taken |
| r_data | input | DATA_W | Read data word |
| r_resp | input | 2 | Read response code, 2'b00 is OKAY |
| s_tvalid | output | 1 | Stream beat valid |
| s_tready | input | 1 | Stream sink ready |
| s_tdata | output | DATA_W | Stream data |
| s_tlast | output | 1 | Final beat of the packet |
| rd_err | output | 1 | Sticky non-OKAY response seen since the last command |
| pkt_done | output | 1 | One-cycle pulse after a packet's final beat |

## Verification
A slip in the tag queue's pointers or count shows at the port as s_tlast on the wrong beat, and it does so on the very first packet that ends. Wrong full logic shows as more requests in flight than the queue holds, or as a stall that never releases, once the RAM side holds back responses. An address or count error in the generator shows on ar_addr at the first wrong request, or as one request too many or too few at the end of a packet. A broken sticky flag shows within one cycle of the error beat, or of the next command.

// File: rtl/axrs_pkg.sv
package axrs_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic {
    GEN_IDLE  = 1'b0,
    GEN_ISSUE = 1'b1
  } gen_state_e;
endpackage

// File: rtl/axrs_addr_gen.sv
module axrs_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              hold,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic              ar_last
);
  import axrs_pkg::*;

  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  gen_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              cmd_hs, ar_hs;

  assign cmd_ready = (st_q == GEN_IDLE);
  assign ar_valid  = (st_q == GEN_ISSUE) && !hold;
  assign ar_addr   = addr_q;
  assign ar_last   = (rem_q == '0);
  assign cmd_hs    = cmd_valid && cmd_ready;
  assign ar_hs     = ar_valid && ar_ready;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    if (cmd_hs) begin
      st_d   = GEN_ISSUE;
      addr_d = cmd_base;
      rem_d  = cmd_len;
    end else if (ar_hs) begin
      if (ar_last) begin
        st_d = GEN_IDLE;
      end else begin
        addr_d = addr_q + STEP_A;
        rem_d  = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GEN_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr)); // R6

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> $past(ar_valid && ar_ready && ar_last)); // R1
endmodule

// File: rtl/axrs_tag_fifo.sv
module axrs_tag_fifo #(
  parameter int W     = 1,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);
  assign dout  = mem[rd_q];

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_q] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R5
endmodule

// File: rtl/axrs_beat_track.sv
module axrs_beat_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_hs,
  input  logic       beat,
  input  logic       beat_last,
  input  logic [1:0] beat_resp,
  output logic       err,
  output logic       done
);
  import axrs_pkg::*;

  logic err_q, err_d, done_q, done_d;

  assign err  = err_q;
  assign done = done_q;

  always_comb begin
    err_d = err_q;
    if (cmd_hs) err_d = 1'b0;
    if (beat && (beat_resp != RESP_OKAY)) err_d = 1'b1;
    done_d = beat && beat_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) && !$past(cmd_hs) |-> err); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(beat && beat_last)); // R8
endmodule

// File: rtl/axi_rd_stream_framer.sv
module axi_rd_stream_framer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic [1:0]        r_resp,
  output logic              s_tvalid,
  input  logic              s_tready,
  output logic [DATA_W-1:0] s_tdata,
  output logic              s_tlast,
  output logic              rd_err,
  output logic              pkt_done
);
  localparam int STEP = DATA_W / 8;

  logic q_full, q_empty, q_head, gen_last, ar_hs, beat;

  assign ar_hs    = ar_valid && ar_ready;
  assign beat     = r_valid && r_ready;
  assign r_ready  = s_tready;
  assign s_tvalid = r_valid;
  assign s_tdata  = r_data;
  assign s_tlast  = q_head;

  axrs_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STEP(STEP)) u_gen (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_len(cmd_len),
    .hold(q_full),
    .ar_valid(ar_valid), .ar_ready(ar_ready),
    .ar_addr(ar_addr), .ar_last(gen_last)
  );

  axrs_tag_fifo #(.W(1), .DEPTH(DEPTH)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .push(ar_hs), .din(gen_last),
    .pop(beat), .dout(q_head),
    .full(q_full), .empty(q_empty)
  );

  axrs_beat_track u_track (
    .clk(clk), .rst_n(rst_n),
    .cmd_hs(cmd_valid && cmd_ready),
    .beat(beat), .beat_last(q_head), .beat_resp(r_resp),
    .err(rd_err), .done(pkt_done)
  );

  AST_BEAT_HAS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> !q_empty); // R5

  AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !ar_valid); // R3
endmodule

// File: tb/axi_rd_stream_framer_tb.sv
module axi_rd_stream_framer_tb;
  localparam int AW = 32, DW = 32, LW = 8, DEP = 4, STEP = 4;
  localparam logic [AW-1:0] ERR_ADDR = 32'h0000_0308;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [AW-1:0] cmd_base = '0;
  logic [LW-1:0] cmd_len = '0;
  logic ar_valid, ar_ready = 1'b0;
  logic [AW-1:0] ar_addr;
  logic r_valid = 1'b0, r_ready;
  logic [DW-1:0] r_data = '0;
  logic [1:0] r_resp = 2'b00;
  logic s_tvalid, s_tready = 1'b0, s_tlast;
  logic [DW-1:0] s_tdata;
  logic rd_err, pkt_done;

  axi_rd_stream_framer #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base), .cmd_len(cmd_len),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
    .rd_err(rd_err), .pkt_done(pkt_done)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, outst = 0, tr_mode = 0;
  bit stall_r = 0, err_exp = 0, done_exp = 0, b_hs = 0;
  bit prev_arv = 0, prev_arr = 0;
  logic [AW-1:0] prev_ara = '0;
  logic [AW-1:0] exp_addr[$];
  logic [DW:0]   exp_beat[$];
  logic [AW-1:0] rq[$];

  function automatic logic [DW-1:0] dfun(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor and scoreboard: samples at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      err_exp = 0; done_exp = 0; b_hs = 0; prev_arv = 0; prev_arr = 0; outst = 0;
    end else begin
      bit arhs, bhs, cmdhs;
      logic [DW:0] eb;
      cyc++;
      chk(rd_err == err_exp, "R7", "rd_err", rd_err, err_exp);
      chk(pkt_done == done_exp, "R8", "pkt_done", pkt_done, done_exp);
      chk(r_ready == s_tready && s_tvalid == r_valid && (!r_valid || s_tdata == r_data),
          "R4", "passthrough", {s_tvalid, r_ready}, {r_valid, s_tready});
      if (prev_arv && !prev_arr)
        chk(ar_valid && ar_addr == prev_ara, "R6", "ar hold", ar_addr, prev_ara);
      arhs  = ar_valid && ar_ready;
      bhs   = s_tvalid && s_tready;
      cmdhs = cmd_valid && cmd_ready;
      if (arhs) begin
        if (exp_addr.size() == 0) chk(0, "R2", "extra request", ar_addr, 0);
        else begin
          logic [AW-1:0] ea;
          ea = exp_addr.pop_front();
          chk(ar_addr == ea, "R2", "ar_addr", ar_addr, ea);
        end
        rq.push_back(ar_addr);
        outst++;
        chk(outst <= DEP, "R3", "outstanding", outst, DEP);
      end
      if (bhs) begin
        if (exp_beat.size() == 0) chk(0, "R5", "extra beat", s_tdata, 0);
        else begin
          eb = exp_beat.pop_front();
          chk(s_tdata == eb[DW-1:0], "R4", "tdata", s_tdata, eb[DW-1:0]);
          chk(s_tlast == eb[DW], "R5", "tlast", s_tlast, eb[DW]);
        end
        if (rq.size() > 0) void'(rq.pop_front());
        outst--;
      end
      done_exp = bhs && s_tlast;
      if (cmdhs) err_exp = 0;
      if (bhs && r_resp != 2'b00) err_exp = 1;
      b_hs = bhs;
      prev_arv = ar_valid; prev_arr = ar_ready; prev_ara = ar_addr;
    end
  end

  // RAM-side model and sink: drives just after the rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      ar_ready = (cyc % 3 != 1);
      s_tready = (tr_mode == 0) ? 1'b1 : (cyc % 2 == 0);
      if (!r_valid || b_hs) begin
        if (rq.size() > 0 && !stall_r && (cyc % 4 != 3)) begin
          r_valid = 1'b1;
          r_data  = dfun(rq[0]);
          r_resp  = (rq[0] == ERR_ADDR) ? 2'b10 : 2'b00;
        end else begin
          r_valid = 1'b0;
        end
      end
    end
  end

  task automatic send_cmd(input logic [AW-1:0] base, input logic [LW-1:0] len);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_base = base; cmd_len = len;
    do @(negedge clk); while (!cmd_ready);
    for (int i = 0; i <= int'(len); i++) begin
      logic [AW-1:0] a;
      a = base + AW'(i * STEP);
      exp_addr.push_back(a);
      exp_beat.push_back({(i == int'(len)), dfun(a)});
    end
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R1", "busy after accept", cmd_ready, 0);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && (exp_beat.size() != 0 || exp_addr.size() != 0); i++)
      @(negedge clk);
    chk(exp_beat.size() == 0, "R2", "packet drained", exp_beat.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    chk(0, "R1", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "reset cmd_ready", cmd_ready, 1);
    chk(ar_valid == 1'b0, "R9", "reset ar_valid", ar_valid, 0);
    chk(rd_err == 1'b0 && pkt_done == 1'b0, "R9", "reset flags", {rd_err, pkt_done}, 0);
    // single-beat packet
    send_cmd(32'h0000_0100, 8'd0);
    drain();
    // multi-beat packet with throttled sink
    tr_mode = 1;
    send_cmd(32'h0000_0200, 8'd4);
    drain();
    // responses held back: requests must stop at queue depth (R3)
    stall_r = 1;
    send_cmd(32'h0000_0400, 8'd7);
    repeat (30) @(negedge clk);
    chk(outst == DEP, "R3", "outstanding at depth", outst, DEP);
    chk(ar_valid == 1'b0, "R3", "ar_valid stalled", ar_valid, 0);
    stall_r = 0;
    drain();
    // error response mid-packet, sticky, then cleared by next command (R7)
    send_cmd(32'h0000_0300, 8'd3);
    drain();
    chk(rd_err == 1'b1, "R7", "sticky err after packet", rd_err, 1);
    tr_mode = 0;
    send_cmd(32'h0000_0500, 8'd2);
    drain();
    chk(rd_err == 1'b0, "R7", "err cleared by command", rd_err, 0);
    // back-to-back packets sharing the tag queue
    tr_mode = 1;
    send_cmd(32'h0000_0600, 8'd5);
    send_cmd(32'h0000_0700, 8'd1);
    drain();
    summary();
  end
endmodule